// File: doc/BRIEF.md
# Branch Target and Direction Predictor

This block sits in the fetch stage and turns the current fetch address into a predicted next fetch address within the same cycle. A direct-mapped target buffer tells it whether the address holds a known control-transfer instruction, what kind of instruction it is and where it goes. For conditional branches, a table of 2-bit saturating counters gives the direction. The table is indexed by the recent global branch outcomes joined with low address bits, so the same branch can be predicted differently depending on the path that led to it. Subroutine returns take their target from a small return-address stack. Fetch-side calls push onto this stack and fetch-side returns pop from it.

The lookup side is a valid/ready stream that passes straight through. A prediction is offered whenever a lookup is valid. The consumer applies back-pressure by holding `pd_ready` low, and `lk_ready` follows `pd_ready`. While the handshake has not completed, the prediction is still shown, but the return stack does not change. The resolve port is a plain one-cycle strobe from the back end. It has no back-pressure. Each strobe rewrites the target buffer entry, trains the counter when the branch is conditional, and shifts the outcome into the history.

Top module: `bpu_next_pc`

## Requirements
- R1: After reset, every buffer entry is invalid, every counter is 00, the history is 0 and the return stack is empty, so any lookup yields next PC = PC+4 with `pd_taken` = 0.
- R2: When the buffer has no valid entry whose stored full-PC tag equals the lookup PC, the prediction is PC+4 and not taken, whatever the counters hold.
- R3: On a hit whose stored kind is conditional (kind code 0), the prediction is taken to the stored target when the selected counter is 10 or 11, and PC+4 with `pd_taken` = 0 when it is 00 or 01.
- R4: A resolve of a conditional branch moves the selected counter up by one if taken and down by one if not taken, saturating at 11 and 00, so a single miss from state 11 leaves the branch predicted taken.
- R5: The counter index is {history[1:0], PC[5:2]}. A lookup uses the current history. A resolve trains the counter at {history before its shift, resolve PC[5:2]}.
- R6: Every resolve, of any kind, shifts the history left by one and puts the resolved outcome in bit 0.
- R7: The buffer has 16 entries indexed by PC[5:2]. Every resolve writes the full PC tag, the target and the kind into its slot, replacing any earlier occupant. The new entry is seen by lookups from the next cycle on.
- R8: A hit whose kind is jump (code 1) or call (code 2) is always predicted taken to the stored target.
- R9: A completed call lookup pushes PC+4. A ret hit (code 3) predicts the stack top as taken when the stack is non-empty, and a completed ret lookup pops that top. With the stack empty, a ret hit predicts PC+4 not taken.
- R10: The return stack holds 8 addresses. A push while it is full is dropped and leaves the contents unchanged.
- R11: `pd_valid` equals `lk_valid` and `lk_ready` equals `pd_ready`. The return stack changes only on a cycle where both `lk_valid` and `pd_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup accepted (follows pd_ready) |
| lk_pc | input | 32 | Fetch address to predict from |
| pd_valid | output | 1 | Prediction valid |
| pd_ready | input | 1 | Consumer takes the prediction |
| pd_next_pc | output | 32 | Predicted next fetch address |
| pd_taken | output | 1 | Prediction redirects away from PC+4 |
| rs_valid | input | 1 | One-cycle resolve strobe |
| rs_pc | input | 32 | Address of the resolved instruction |
| rs_target | input | 32 | Its taken target |
| rs_kind | input | 2 | 0 conditional, 1 jump, 2 call, 3 ret |
| rs_taken | input | 1 | Resolved outcome |

## Verification
The bench trains a single branch through the counter states and checks four behaviours. The weak not-taken state (01) must still fall through, and the counter must clamp at 00. A lone miss from the strong taken state must not flip the prediction. A design that wraps the counter or treats 01 as taken would redirect on these lookups. The bench also changes only the history to show that one address picks a different counter, and it evicts a trained branch by aliasing its slot, so a partial tag or an index without history would be caught. On the return stack, it fills the stack past capacity with two distinguishable return addresses, pops while the stack is empty, and stalls `pd_ready` on calls and returns; a stack that overwrites or wraps, or moves without a handshake, returns the wrong address.

// File: rtl/bpu_pkg.sv
`timescale 1ns/1ps
package bpu_pkg;
  // Kind of control-transfer instruction held in a target-buffer entry.
  typedef enum logic [1:0] {
    BK_COND = 2'd0,
    BK_JUMP = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bpu_btb.sv
`timescale 1ns/1ps
module bpu_btb
  import bpu_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  output br_kind_e        lk_kind,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target,
  input  br_kind_e        wr_kind
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0]    vld_q;
  logic [PC_W-1:0] tag_q [N];
  logic [PC_W-1:0] tgt_q [N];
  br_kind_e        kind_q [N];

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] wr_idx;

  // Word-aligned addresses: the slot comes from the bits just above the byte offset.
  assign lk_idx = lk_pc[IDX_W+1:2];
  assign wr_idx = wr_pc[IDX_W+1:2];

  assign lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_pc);
  assign lk_target = tgt_q[lk_idx];
  assign lk_kind   = kind_q[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_pc;
      tgt_q[wr_idx]  <= wr_target;
      kind_q[wr_idx] <= wr_kind;
    end
  end

  // R7
  btb_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/bpu_dir_table.sv
`timescale 1ns/1ps
module bpu_dir_table #(
  parameter int HIST_W = 2,
  parameter int PCB_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PCB_W-1:0] lk_pcb,
  output logic             lk_taken,
  input  logic             up_en,
  input  logic             sh_en,
  input  logic [PCB_W-1:0] up_pcb,
  input  logic             up_taken
);
  localparam int IDX_W = HIST_W + PCB_W;
  localparam int N     = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q;
  logic [1:0]        ctr_q [N];
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  up_idx;
  logic [1:0]        up_cur;
  logic [1:0]        up_nxt;

  assign lk_idx   = {hist_q, lk_pcb};
  assign up_idx   = {hist_q, up_pcb};
  assign lk_taken = ctr_q[lk_idx][1];
  assign up_cur   = ctr_q[up_idx];

  // Saturating step: no wrap at either end.
  always_comb begin
    up_nxt = up_cur;
    if (up_taken && up_cur != 2'b11) begin
      up_nxt = up_cur + 2'b01;
    end else if (!up_taken && up_cur != 2'b00) begin
      up_nxt = up_cur - 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) begin
        ctr_q[e] <= 2'b00;
      end
    end else if (up_en) begin
      ctr_q[up_idx] <= up_nxt;
    end
  end

  generate
    if (HIST_W == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hist_q <= '0;
        else if (sh_en) hist_q <= up_taken;
      end
    end else begin : g_histn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hist_q <= '0;
        else if (sh_en) hist_q <= {hist_q[HIST_W-2:0], up_taken};
      end
    end
  endgenerate

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |=> hist_q[0] == $past(up_taken));
  // R4
  ctr_sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_taken && up_cur == 2'b11) |=> ctr_q[$past(up_idx)] == 2'b11);
endmodule

// File: rtl/bpu_ras.sv
`timescale 1ns/1ps
module bpu_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [PC_W-1:0] push_addr,
  input  logic            pop,
  output logic [PC_W-1:0] top_addr,
  output logic            empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  stack_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_m1;
  logic             full;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign cnt_m1   = cnt_q - CNT_W'(1);
  assign top_addr = stack_q[cnt_m1[PTR_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push && !full) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt_q <= cnt_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      stack_q[cnt_q[PTR_W-1:0]] <= push_addr;
    end
  end

  // R10
  ras_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ($stable(cnt_q) && $stable(top_addr)));
  // R9
  ras_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/bpu_next_pc.sv
`timescale 1ns/1ps
module bpu_next_pc
  import bpu_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int BTB_IDX_W = 4,
  parameter int HIST_W    = 2,
  parameter int PCB_W     = 4,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pd_valid,
  input  logic            pd_ready,
  output logic [PC_W-1:0] pd_next_pc,
  output logic            pd_taken,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic [PC_W-1:0] rs_target,
  input  logic [1:0]      rs_kind,
  input  logic            rs_taken
);
  logic [PC_W-1:0] pc_plus;
  logic            btb_hit;
  logic [PC_W-1:0] btb_tgt;
  br_kind_e        btb_kind;
  logic            dir_taken;
  logic [PC_W-1:0] ras_top;
  logic            ras_empty;
  logic            fire;
  logic            ras_push;
  logic            ras_pop;
  br_kind_e        rs_kind_e;

  assign rs_kind_e = br_kind_e'(rs_kind);
  assign pc_plus   = lk_pc + PC_W'(4);
  assign fire      = lk_valid && pd_ready;
  assign lk_ready  = pd_ready;
  assign pd_valid  = lk_valid;

  bpu_btb #(.PC_W(PC_W), .IDX_W(BTB_IDX_W)) u_btb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_hit    (btb_hit),
    .lk_target (btb_tgt),
    .lk_kind   (btb_kind),
    .wr_en     (rs_valid),
    .wr_pc     (rs_pc),
    .wr_target (rs_target),
    .wr_kind   (rs_kind_e)
  );

  bpu_dir_table #(.HIST_W(HIST_W), .PCB_W(PCB_W)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pcb   (lk_pc[PCB_W+1:2]),
    .lk_taken (dir_taken),
    .up_en    (rs_valid && rs_kind_e == BK_COND),
    .sh_en    (rs_valid),
    .up_pcb   (rs_pc[PCB_W+1:2]),
    .up_taken (rs_taken)
  );

  bpu_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ras_push),
    .push_addr (pc_plus),
    .pop       (ras_pop),
    .top_addr  (ras_top),
    .empty     (ras_empty)
  );

  assign ras_push = fire && btb_hit && btb_kind == BK_CALL;
  assign ras_pop  = fire && btb_hit && btb_kind == BK_RET;

  always_comb begin
    pd_taken   = 1'b0;
    pd_next_pc = pc_plus;
    if (btb_hit) begin
      unique case (btb_kind)
        BK_COND: begin
          pd_taken   = dir_taken;
          pd_next_pc = dir_taken ? btb_tgt : pc_plus;
        end
        BK_JUMP, BK_CALL: begin
          pd_taken   = 1'b1;
          pd_next_pc = btb_tgt;
        end
        BK_RET: begin
          pd_taken   = !ras_empty;
          pd_next_pc = ras_empty ? pc_plus : ras_top;
        end
        default: ;
      endcase
    end
  end

  // R2
  miss_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !btb_hit) |-> (pd_next_pc == lk_pc + PC_W'(4) && !pd_taken));
  // R8
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_taken |-> btb_hit);
  // R11
  ras_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(ras_empty) && $stable(ras_top)));
endmodule

// File: tb/test_bpu_next_pc.sv
`timescale 1ns/1ps
module test_bpu_next_pc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_pc = '0;
  logic        pd_valid;
  logic        pd_ready = 1'b0;
  logic [31:0] pd_next_pc;
  logic        pd_taken;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic [31:0] rs_target = '0;
  logic [1:0]  rs_kind = '0;
  logic        rs_taken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] K_COND = 2'd0, K_JUMP = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  always #2.5 clk = ~clk;

  bpu_next_pc i_bpu_next_pc (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .pd_valid(pd_valid), .pd_ready(pd_ready), .pd_next_pc(pd_next_pc), .pd_taken(pd_taken),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_target(rs_target), .rs_kind(rs_kind),
    .rs_taken(rs_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lk_valid = 1'b0; rs_valid = 1'b0; pd_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic [31:0] tgt,
                         input logic [1:0] kind, input logic tk);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_target = tgt; rs_kind = kind; rs_taken = tk;
    @(posedge clk);
    #1 rs_valid = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic rdy,
                      input logic [31:0] exp_pc, input logic exp_tk);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; pd_ready = rdy;
    #1;
    chk({req, " next_pc"}, pd_next_pc, exp_pc);
    chk({req, " taken"}, {31'd0, pd_taken}, {31'd0, exp_tk});
    chk({req, " R11 handshake"}, {30'd0, pd_valid, lk_ready}, {30'd0, 1'b1, rdy});
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  // R1: empty predictor falls through
  task automatic t_reset();
    do_reset();
    #1 chk("R1 pd_valid idle", {31'd0, pd_valid}, 32'd0);
    look("R1", 32'h1234_5678, 1'b1, 32'h1234_567C, 1'b0);
  endtask

  // R3 R4 R5: train one conditional branch at A (slot 4)
  task automatic t_direction();
    do_reset();
    resolve(32'h1010, 32'h2000, K_COND, 1'b1);  // ctr{00,4}=1 hist=01
    resolve(32'h1010, 32'h2000, K_COND, 1'b1);  // ctr{01,4}=1 hist=11
    resolve(32'h1010, 32'h2000, K_COND, 1'b1);  // ctr{11,4}=1
    look("R3 weak not-taken", 32'h1010, 1'b1, 32'h1014, 1'b0);
    resolve(32'h1010, 32'h2000, K_COND, 1'b1);  // ctr{11,4}=2
    look("R3 weak taken", 32'h1010, 1'b1, 32'h2000, 1'b1);
    resolve(32'h1010, 32'h2000, K_COND, 1'b1);  // 3
    resolve(32'h1010, 32'h2000, K_COND, 1'b1);  // stays 3
    resolve(32'h1010, 32'h2000, K_COND, 1'b0);  // ctr{11,4}=2 hist=10
    resolve(32'h1010, 32'h2000, K_COND, 1'b1);  // ctr{10,4}=1 hist=01
    resolve(32'h1010, 32'h2000, K_COND, 1'b1);  // ctr{01,4}=2 hist=11
    look("R4 hysteresis", 32'h1010, 1'b1, 32'h2000, 1'b1);
    // floor clamp: from reset one not-taken keeps 00 at hist 00
    do_reset();
    resolve(32'h1010, 32'h2000, K_COND, 1'b0);  // ctr{00,4}=0 hist=00
    look("R4 floor clamp", 32'h1010, 1'b1, 32'h1014, 1'b0);
  endtask

  // R5 R6: same address, prediction set by history only
  task automatic t_history();
    do_reset();
    repeat (4) resolve(32'h1010, 32'h2000, K_COND, 1'b1); // ctr{11,4}=2 hist=11
    look("R5 history 11", 32'h1010, 1'b1, 32'h2000, 1'b1);
    resolve(32'h3020, 32'h4000, K_COND, 1'b0);            // hist=10
    look("R6 history 10", 32'h1010, 1'b1, 32'h1014, 1'b0);
    resolve(32'h3020, 32'h4000, K_JUMP, 1'b1);            // hist=01
    look("R6 jump shifts", 32'h1010, 1'b1, 32'h1014, 1'b0);
    resolve(32'h3020, 32'h4000, K_JUMP, 1'b1);            // hist=11
    look("R6 back to 11", 32'h1010, 1'b1, 32'h2000, 1'b1);
    // alias slot 4 with a jump: trained branch now misses
    resolve(32'h1050, 32'h5000, K_JUMP, 1'b1);
    look("R2 evicted branch", 32'h1010, 1'b1, 32'h1014, 1'b0);
  endtask

  // R2 R7 R8: tags and replacement
  task automatic t_btb();
    do_reset();
    resolve(32'h0100, 32'h0400, K_JUMP, 1'b1);
    look("R8 jump", 32'h0100, 1'b1, 32'h0400, 1'b1);
    look("R2 tag mismatch", 32'h0140, 1'b1, 32'h0144, 1'b0);
    resolve(32'h0140, 32'h0800, K_CALL, 1'b1);
    look("R7 replaced", 32'h0140, 1'b0, 32'h0800, 1'b1);
    look("R7 old evicted", 32'h0100, 1'b1, 32'h0104, 1'b0);
  endtask

  // R9 R11: calls, returns and back-pressure
  task automatic t_ras_basic();
    do_reset();
    resolve(32'h0200, 32'h0600, K_CALL, 1'b1);
    resolve(32'h0208, 32'h0700, K_CALL, 1'b1);
    resolve(32'h0604, 32'h0000, K_RET, 1'b1);
    look("R9 ret empty", 32'h0604, 1'b1, 32'h0608, 1'b0);
    look("R11 call stalled", 32'h0200, 1'b0, 32'h0600, 1'b1);
    look("R11 no push", 32'h0604, 1'b1, 32'h0608, 1'b0);
    look("R9 call", 32'h0200, 1'b1, 32'h0600, 1'b1);
    look("R9 call2", 32'h0208, 1'b1, 32'h0700, 1'b1);
    look("R11 ret stalled", 32'h0604, 1'b0, 32'h020C, 1'b1);
    look("R9 pop inner", 32'h0604, 1'b1, 32'h020C, 1'b1);
    look("R9 pop outer", 32'h0604, 1'b1, 32'h0204, 1'b1);
    look("R9 pop empty", 32'h0604, 1'b1, 32'h0608, 1'b0);
  endtask

  // R10: push past capacity is dropped
  task automatic t_ras_full();
    do_reset();
    resolve(32'h0200, 32'h0600, K_CALL, 1'b1);
    resolve(32'h0208, 32'h0700, K_CALL, 1'b1);
    resolve(32'h0604, 32'h0000, K_RET, 1'b1);
    repeat (7) look("R10 fill", 32'h0200, 1'b1, 32'h0600, 1'b1);
    look("R10 eighth", 32'h0208, 1'b1, 32'h0700, 1'b1);
    look("R10 ninth", 32'h0200, 1'b1, 32'h0600, 1'b1);
    look("R10 top kept", 32'h0604, 1'b1, 32'h020C, 1'b1);
    for (int i = 0; i < 7; i++) look("R10 drain", 32'h0604, 1'b1, 32'h0204, 1'b1);
    look("R10 drained", 32'h0604, 1'b1, 32'h0608, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_direction();
    t_history();
    t_btb();
    t_ras_basic();
    t_ras_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule